// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow Trap

This block is the add/subtract datapath of a simple processor's integer unit. Each cycle it may accept one operation. The operation is two 32-bit operands, a select between sum and difference, and a flag that marks the checked (signed, trapping) form of the instruction. The unchecked form wraps silently. The block computes the result and a signed-overflow indication in the same cycle. A difference is formed as the first operand plus the inverted second operand plus one.

When a checked operation overflows, the block holds back the register write by dropping the result-valid strobe. At the next clock edge it latches the faulting instruction's program counter into an exception PC register. It also raises a one-cycle redirect request that carries a fixed handler address. A read port returns the saved exception PC, so that handler software can resume after a correction.

Top module: `addsub_trap_unit`

## Requirements
- R1: With `sub_sel`=0, `result` equals `opnd_a + opnd_b` modulo 2^32 in the same cycle.
- R2: With `sub_sel`=1, `result` equals `opnd_a + ~opnd_b + 1` (that is, `opnd_a - opnd_b`) modulo 2^32 in the same cycle.
- R3: For a sum, `ovf` is 0 when the operand sign bits (bit 31) differ. When they match, `ovf` is 1 exactly when the result's bit 31 differs from them.
- R4: For a difference, `ovf` is 0 when the operand sign bits match. When they differ, `ovf` is 1 exactly when the result's bit 31 differs from `opnd_a`'s bit 31.
- R5: With `trap_en`=0, overflow has no effect: `result_valid` follows `op_valid`, no redirect follows, and the exception PC keeps its value.
- R6: With `op_valid`=1, `trap_en`=1 and overflow, `result_valid` is 0 while `result` still shows the wrapped value.
- R7: A trapping overflow makes `redirect` 1 for exactly the following cycle. `redirect_addr` equals parameter `HANDLER_ADDR` while `redirect` is 1, and 0 otherwise.
- R8: At the edge ending a trapping overflow, the exception PC takes `op_pc`. `epc_rdata` shows the exception PC while `epc_rd` is 1, and 0 while it is 0.
- R9: After synchronous reset, the exception PC is 0 and `redirect` is 0.
- R10: A read of the exception PC in the same cycle as a trapping overflow returns the value held before that overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| sub_sel | input | 1 | 0 selects sum, 1 selects difference |
| trap_en | input | 1 | 1 marks the checked, trapping form |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_pc | input | 32 | Program counter of the presented operation |
| result | output | 32 | Wrapped sum or difference |
| ovf | output | 1 | Signed overflow of the current result |
| result_valid | output | 1 | Destination write enable |
| redirect | output | 1 | One-cycle request to jump to the handler |
| redirect_addr | output | 32 | Handler address while redirect is high |
| epc_rd | input | 1 | Read strobe for the exception PC |
| epc_rdata | output | 32 | Exception PC read data |

## Verification
A read of the exception PC and a new trapping overflow can fall in the same cycle. In that cycle the register is being loaded at the coming edge while its old contents are on the read port. The bench provokes this with back-to-back overflowing checked operations that carry distinct PCs, with `epc_rd` held high throughout. It expects the earlier PC during the second overflow and the later PC one cycle after. Random vectors that mix both operation forms, with the read strobe toggled at random, are compared each clock against a behavioural model that finds overflow by wide signed arithmetic rather than by sign bits.

// File: rtl/addsub_pkg.sv
`timescale 1ns/1ps
package addsub_pkg;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned PC_W   = 32;
    localparam int unsigned MSB   = DATA_W - 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PC_W-1:0]   pc_t;

    typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_kind_e;

    typedef struct packed {
        word_t sum;
        logic  ovf;
    } alu_out_t;

    function automatic logic signed_ovf(input op_kind_e k, input logic a_s,
                                        input logic b_s, input logic r_s);
        logic same;
        same = (a_s == b_s);
        if (k == OP_ADD) return same && (r_s != a_s);
        else             return !same && (r_s != a_s);
    endfunction
endpackage

// File: rtl/addsub_core.sv
`timescale 1ns/1ps
module addsub_core
    import addsub_pkg::*;
(
    input  word_t    a,
    input  word_t    b,
    input  op_kind_e kind,
    output word_t    sum
);
    word_t b_eff;
    logic  cin;

    always_comb begin
        cin   = (kind == OP_SUB);
        b_eff = cin ? ~b : b;
        sum   = a + b_eff + DATA_W'(cin);
    end
endmodule

// File: rtl/ovf_detect.sv
`timescale 1ns/1ps
module ovf_detect
    import addsub_pkg::*;
(
    input  word_t    a,
    input  word_t    b,
    input  word_t    sum,
    input  op_kind_e kind,
    output alu_out_t out
);
    always_comb begin
        out.sum = sum;
        out.ovf = signed_ovf(kind, a[MSB], b[MSB], sum[MSB]);
    end
endmodule

// File: rtl/trap_ctrl.sv
`timescale 1ns/1ps
module trap_ctrl
    import addsub_pkg::*;
#(
    parameter pc_t HANDLER_ADDR = 32'h0000_0400
)(
    input  logic clk,
    input  logic rst,
    input  logic trap_fire,
    input  pc_t  fault_pc,
    input  logic rd_en,
    output logic redirect,
    output pc_t  redirect_addr,
    output pc_t  rd_data
);
    pc_t epc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q    <= '0;
            redirect <= 1'b0;
        end else begin
            redirect <= trap_fire;
            if (trap_fire) epc_q <= fault_pc;
        end
    end

    always_comb begin
        redirect_addr = redirect ? HANDLER_ADDR : '0;
        rd_data       = rd_en ? epc_q : '0;
    end

    // R7: pulse follows a trap by one cycle and only then
    assert_redirect_after_trap_R7: assert property (@(posedge clk) disable iff (rst)
        trap_fire |=> redirect);
    assert_redirect_single_R7: assert property (@(posedge clk) disable iff (rst)
        !trap_fire |=> !redirect);
    // R8: faulting PC captured
    assert_epc_capture_R8: assert property (@(posedge clk) disable iff (rst)
        trap_fire |=> epc_q == $past(fault_pc));
    // R5: exception PC untouched without a trap
    assert_epc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !trap_fire |=> $stable(epc_q));
endmodule

// File: rtl/addsub_trap_unit.sv
`timescale 1ns/1ps
module addsub_trap_unit
    import addsub_pkg::*;
#(
    parameter logic [31:0] HANDLER_ADDR = 32'h0000_0400
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic        sub_sel,
    input  logic        trap_en,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [31:0] op_pc,
    output logic [31:0] result,
    output logic        ovf,
    output logic        result_valid,
    output logic        redirect,
    output logic [31:0] redirect_addr,
    input  logic        epc_rd,
    output logic [31:0] epc_rdata
);
    op_kind_e kind;
    word_t    raw_sum;
    alu_out_t alu;
    logic     trap_fire;

    assign kind = sub_sel ? OP_SUB : OP_ADD;

    addsub_core u_core (.a(opnd_a), .b(opnd_b), .kind(kind), .sum(raw_sum));

    ovf_detect u_ovf (.a(opnd_a), .b(opnd_b), .sum(raw_sum), .kind(kind), .out(alu));

    always_comb begin
        result       = alu.sum;
        ovf          = alu.ovf;
        trap_fire    = op_valid && trap_en && alu.ovf;
        result_valid = op_valid && !trap_fire;
    end

    trap_ctrl #(.HANDLER_ADDR(HANDLER_ADDR)) u_trap (
        .clk(clk), .rst(rst), .trap_fire(trap_fire), .fault_pc(op_pc),
        .rd_en(epc_rd), .redirect(redirect), .redirect_addr(redirect_addr),
        .rd_data(epc_rdata)
    );

    // R3: opposite-sign sums never overflow
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !sub_sel && (opnd_a[31] != opnd_b[31])) |-> !ovf);
    // R4: equal-sign differences never overflow
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && sub_sel && (opnd_a[31] == opnd_b[31])) |-> !ovf);
    // R6: trapping overflow suppresses the write
    assert_write_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && trap_en && ovf) |-> !result_valid);
    // R5: unchecked form always writes
    assert_unchecked_writes_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !trap_en) |-> result_valid);
endmodule

// File: tb/test_addsub_trap_unit.sv
`timescale 1ns/1ps
module test_addsub_trap_unit;
    localparam logic [31:0] HANDLER = 32'h0000_0400;

    logic clk = 1'b0;
    logic rst;
    logic op_valid, sub_sel, trap_en, epc_rd;
    logic [31:0] opnd_a, opnd_b, op_pc;
    logic [31:0] result, redirect_addr, epc_rdata;
    logic ovf, result_valid, redirect;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    // behavioural model state
    logic [31:0] m_epc;
    logic        m_red;

    always #2 clk = ~clk;

    addsub_trap_unit #(.HANDLER_ADDR(HANDLER)) i_addsub_trap_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .sub_sel(sub_sel),
        .trap_en(trap_en), .opnd_a(opnd_a), .opnd_b(opnd_b), .op_pc(op_pc),
        .result(result), .ovf(ovf), .result_valid(result_valid),
        .redirect(redirect), .redirect_addr(redirect_addr),
        .epc_rd(epc_rd), .epc_rdata(epc_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic s, input logic t,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] pc, input logic rd);
        longint sa, sb, full;
        logic [31:0] e_res;
        logic e_ovf, fire;
        op_valid = v; sub_sel = s; trap_en = t;
        opnd_a = a; opnd_b = b; op_pc = pc; epc_rd = rd;
        #1;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        full = s ? sa - sb : sa + sb;
        e_res = full[31:0];
        e_ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
        fire = v && t && e_ovf;
        if (s) begin
            chk("R2 result", result, e_res);
            chk("R4 ovf", {31'b0, ovf}, {31'b0, e_ovf});
        end else begin
            chk("R1 result", result, e_res);
            chk("R3 ovf", {31'b0, ovf}, {31'b0, e_ovf});
        end
        if (fire) chk("R6 result_valid", {31'b0, result_valid}, 32'd0);
        else      chk("R5 result_valid", {31'b0, result_valid}, {31'b0, v});
        chk("R7 redirect", {31'b0, redirect}, {31'b0, m_red});
        chk("R7 redirect_addr", redirect_addr, m_red ? HANDLER : 32'd0);
        // R10: read during a trap cycle shows the pre-trap value
        chk(fire ? "R10 epc_rdata" : "R8 epc_rdata", epc_rdata, rd ? m_epc : 32'd0);
        @(posedge clk);
        m_red = fire;
        if (fire) m_epc = pc;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        op_valid = 0; sub_sel = 0; trap_en = 0; epc_rd = 0;
        opnd_a = 0; opnd_b = 0; op_pc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_epc = 0; m_red = 0;
        epc_rd = 1;
        #1;
        chk("R9 epc after reset", epc_rdata, 32'd0);
        chk("R9 redirect after reset", {31'b0, redirect}, 32'd0);
        @(negedge clk);

        // R1/R3 plain sums
        apply(1, 0, 1, 32'd7, 32'd6, 32'h100, 1);
        apply(1, 0, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h104, 1); // opposite signs
        apply(1, 0, 0, 32'h7FFF_FFFF, 32'd1, 32'h108, 1);         // R5 wraps silently
        apply(1, 0, 0, 32'h8000_0000, 32'h8000_0000, 32'h10C, 1); // R5 neg+neg
        apply(0, 0, 1, 32'h7FFF_FFFF, 32'd1, 32'h110, 1);         // invalid: no trap
        // R2/R4 differences
        apply(1, 1, 1, 32'd7, 32'd6, 32'h114, 1);
        apply(1, 1, 1, 32'h8000_0000, 32'h8000_0000, 32'h118, 1); // equal signs
        apply(1, 1, 0, 32'h8000_0000, 32'd1, 32'h11C, 1);         // R5 neg-pos
        // trapping overflow, R6/R7/R8
        apply(1, 0, 1, 32'h7FFF_FFFF, 32'd1, 32'h200, 1);
        apply(1, 0, 0, 32'd1, 32'd2, 32'h204, 1);                 // redirect visible
        apply(1, 0, 0, 32'd1, 32'd2, 32'h208, 0);                 // redirect gone, rd=0
        // R10: back-to-back traps with reads
        apply(1, 1, 1, 32'h8000_0000, 32'd1, 32'h300, 1);
        apply(1, 1, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h304, 1);
        apply(1, 0, 1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h308, 1);
        apply(1, 0, 0, 32'd0, 32'd0, 32'h30C, 1);
        apply(0, 0, 0, 32'd0, 32'd0, 32'h310, 1);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 4 == 0) ra[30:0] = {31{ra[31]}} ^ 31'h7FFF_FFFF;
            apply($urandom % 8 != 0, 1'($urandom), 1'($urandom), ra, rb,
                  32'($urandom) & 32'hFFFF_FFFC, 1'($urandom));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule